// File: doc/BRIEF.md
# Bus-Master Flash Access Filter

This block stands between the bus masters of a small controller (CPU instruction fetch, CPU data fetch, DMA and the debugger) and the memory-mapped internal flash, internal RAM and the window through which the debugger reaches CPU registers and single-step control. For every request it decides at once whether the access may proceed. The decision depends on three things: which master asked, the physical region the address maps to, and the current protection level. A granted read passes the memory's data through. A blocked access is not granted, returns all zeros, raises a violation flag for that cycle and adds one to a saturating violation counter.

Address checking follows an allow-list. Only the flash window, its low alias, the RAM window and the debug-register window are reachable, and every other address is refused. The flash alias is first reduced to the same physical region as the main flash address, so both addresses always get the same verdict. Part of the flash is an execute-only area: only instruction fetch may read it. The protection level sits in a register that can only become stricter until the next reset. The decode is purely combinational, so a new level applies to every request from the first cycle after it is written, with no window in which one word can slip out.

Top module: `bm_access_gate`

## Requirements
- R1: Only four windows are reachable: flash at 0x0800_0000–0x0800_FFFF, its alias at 0x0000_0000–0x0000_FFFF, RAM at 0x2000_0000–0x2000_3FFF and the debug-register window at 0xE000_0000–0xE000_00FF. Any other address is denied to every master.
- R2: An address in the flash alias gets the same grant decision as the flash address with the same low 16 bits.
- R3: Flash offsets 0x8000–0x8FFF are execute-only. Only a read by master code 0 (instruction fetch) is granted there. Masters 1 (data fetch), 2 (DMA) and 3 (debug) are denied there for reads and writes alike.
- R4: Master 0 reads of flash and RAM are granted at every protection level. Writes by master 0 are always denied.
- R5: Master 1 and master 2 may access flash outside the execute-only area and RAM, at every protection level. They never get the debug-register window.
- R6: At protection level 0 (open), master 3 may access flash outside the execute-only area, RAM and the debug-register window.
- R7: At protection level 1 (partial), master 3 is denied flash and the debug-register window, and still reaches RAM.
- R8: At protection levels 2 and 3 (full lockout), every master 3 request is denied.
- R9: grant and rsp_rdata follow the request in the same cycle. A level write applies from the cycle right after the clock edge that stores it, so the first debug request in that cycle is already judged at the new level.
- R10: When a valid request is denied, grant is 0, rsp_rdata is all zeros and viol is 1 in that cycle. When a request is granted, viol is 0 and rsp_rdata equals mem_rdata.
- R11: viol_count resets to 0, rises by one at each clock edge where viol is 1, stops at its all-ones value and otherwise holds.
- R12: prot_level resets to 0. A write is stored only if its value is greater than the current level, so a write that would lower it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_master | input | 2 | Requesting master: 0 instruction fetch, 1 data fetch, 2 DMA, 3 debug |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| mem_rdata | input | DW | Read data from the memory side |
| lvl_wr_en | input | 1 | Request to store a new protection level |
| lvl_wr_val | input | 2 | Proposed protection level |
| grant | output | 1 | The request may proceed to the memory |
| rsp_rdata | output | DW | Read data returned to the master, zero when blocked |
| viol | output | 1 | A valid request was refused this cycle |
| viol_count | output | CNT_W | Saturating count of refused requests |
| prot_level | output | 2 | Current protection level |

## Verification
A table of requests covers each master against each window at each of the three level classes. It separates the per-master rules from the level rules, and a main address from its alias. Execute-only probes with every master show that the restriction comes from the master and not from the address alone. Addresses just past the flash end and in an unmapped area show that the check is an allow-list. Directed sequences then issue a debug request in the cycle right after a level write, try to lower the level, drive the counter into saturation and check the state after reset.

// File: rtl/acc_gate_pkg.sv
`timescale 1ns/1ps
// Shared types for the bus-master access filter.
// Assumes a two-bit master code and a two-bit protection level.
package acc_gate_pkg;

    typedef enum logic [1:0] {
        MST_IFETCH = 2'd0,
        MST_DFETCH = 2'd1,
        MST_DMA    = 2'd2,
        MST_DEBUG  = 2'd3
    } master_e;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_FLASH = 2'd1,
        RGN_RAM   = 2'd2,
        RGN_DREG  = 2'd3
    } region_e;

    localparam logic [1:0] LVL_OPEN = 2'd0;
    localparam logic [1:0] LVL_PART = 2'd1;
    localparam logic [1:0] LVL_FULL = 2'd2;

    typedef struct packed {
        region_e rgn;
        logic    xo;
    } decode_t;

endpackage

// File: rtl/acc_region_decode.sv
`timescale 1ns/1ps
// Maps an address onto a physical region (allow-list) and flags the
// execute-only area of flash. The low alias of flash folds onto the same
// region, so both addresses share one verdict.
// Assumes every window is naturally aligned to its power-of-two size.
module acc_region_decode
    import acc_gate_pkg::*;
#(
    parameter int unsigned    AW          = 32,
    parameter int unsigned    FLASH_LOG2  = 16,
    parameter logic [AW-1:0]  FLASH_BASE  = 32'h0800_0000,
    parameter bit             ALIAS_EN    = 1'b1,
    parameter logic [AW-1:0]  ALIAS_BASE  = 32'h0000_0000,
    parameter int unsigned    XO_LOG2     = 12,
    parameter logic [AW-1:0]  XO_OFS      = 32'h0000_8000,
    parameter int unsigned    RAM_LOG2    = 14,
    parameter logic [AW-1:0]  RAM_BASE    = 32'h2000_0000,
    parameter int unsigned    DREG_LOG2   = 8,
    parameter logic [AW-1:0]  DREG_BASE   = 32'hE000_0000
) (
    input  logic [AW-1:0] addr,
    output decode_t       dec
);

    logic flash_main_hit;
    logic flash_alias_hit;
    logic ram_hit;
    logic dreg_hit;
    logic xo_hit;

    // Window compares on the upper address bits.
    assign flash_main_hit = (addr[AW-1:FLASH_LOG2] == FLASH_BASE[AW-1:FLASH_LOG2]);
    assign ram_hit        = (addr[AW-1:RAM_LOG2]   == RAM_BASE[AW-1:RAM_LOG2]);
    assign dreg_hit       = (addr[AW-1:DREG_LOG2]  == DREG_BASE[AW-1:DREG_LOG2]);
    assign xo_hit         = (addr[FLASH_LOG2-1:XO_LOG2] == XO_OFS[FLASH_LOG2-1:XO_LOG2]);

    // The alias window exists only when the parameter selects it.
    generate
        if (ALIAS_EN) begin : g_alias
            assign flash_alias_hit = (addr[AW-1:FLASH_LOG2] == ALIAS_BASE[AW-1:FLASH_LOG2]);
        end else begin : g_no_alias
            assign flash_alias_hit = 1'b0;
        end
    endgenerate

    // Pick the region; anything not listed stays RGN_NONE.
    always_comb begin
        dec.rgn = RGN_NONE;
        dec.xo  = 1'b0;
        if (flash_main_hit || flash_alias_hit) begin
            dec.rgn = RGN_FLASH;
            dec.xo  = xo_hit;
        end else if (ram_hit) begin
            dec.rgn = RGN_RAM;
        end else if (dreg_hit) begin
            dec.rgn = RGN_DREG;
        end
    end

endmodule

// File: rtl/acc_policy.sv
`timescale 1ns/1ps
// Combinational permission table: master x region x level -> allow.
// Assumes levels 2 and 3 both mean full debug lockout.
module acc_policy
    import acc_gate_pkg::*;
(
    input  master_e    master,
    input  decode_t    dec,
    input  logic       is_write,
    input  logic [1:0] level,
    output logic       allow
);

    logic plain_flash;
    logic lock_full;
    logic lock_part;

    assign plain_flash = (dec.rgn == RGN_FLASH) && !dec.xo;
    assign lock_full   = (level >= LVL_FULL);
    assign lock_part   = (level == LVL_PART);

    // Per-master permission rules.
    always_comb begin
        allow = 1'b0;
        unique case (master)
            MST_IFETCH: allow = !is_write &&
                                ((dec.rgn == RGN_FLASH) || (dec.rgn == RGN_RAM));
            MST_DFETCH,
            MST_DMA:    allow = plain_flash || (dec.rgn == RGN_RAM);
            MST_DEBUG: begin
                if (lock_full)      allow = 1'b0;
                else if (lock_part) allow = (dec.rgn == RGN_RAM);
                else                allow = plain_flash || (dec.rgn == RGN_RAM) ||
                                            (dec.rgn == RGN_DREG);
            end
            default:    allow = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_level_reg.sv
`timescale 1ns/1ps
// Protection level register that only ever moves to a stricter value
// until reset. Assumes a larger code means stricter.
module acc_level_reg #(
    parameter logic [1:0] RST_LEVEL = 2'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_val,
    output logic [1:0] level
);

    // Store only writes that raise the level.
    always_ff @(posedge clk) begin
        if (!rst_n)                        level <= RST_LEVEL;
        else if (wr_en && wr_val > level)  level <= wr_val;
    end

    // R12
    lvl_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> level >= $past(level));

    // R12
    lvl_lower_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_val <= level) |=> $stable(level));

endmodule

// File: rtl/acc_viol_counter.sv
`timescale 1ns/1ps
// Saturating counter of refused requests.
// Assumes at most one violation per cycle.
module acc_viol_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count up on each violation, stopping at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                      count <= '0;
        else if (hit && count != CNT_MAX) count <= count + 1'b1;
    end

    // R11
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && count == CNT_MAX) |=> count == CNT_MAX);

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && count != CNT_MAX) |=> count == $past(count) + 1'b1);

    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(count));

endmodule

// File: rtl/bm_access_gate.sv
`timescale 1ns/1ps
// Bus-master access filter: per-request grant/deny between bus masters
// and flash, RAM and the debug-register window. Decision is combinational
// on the request; only the level and the violation count are stored.
// Assumes the memory side honours grant and that mem_rdata is valid in
// the request cycle.
module bm_access_gate
    import acc_gate_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned DW        = 32,
    parameter int unsigned CNT_W     = 8,
    parameter logic [1:0]  RST_LEVEL = 2'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_master,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_write,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             lvl_wr_en,
    input  logic [1:0]       lvl_wr_val,
    output logic             grant,
    output logic [DW-1:0]    rsp_rdata,
    output logic             viol,
    output logic [CNT_W-1:0] viol_count,
    output logic [1:0]       prot_level
);

    decode_t dec;
    logic    allow;
    master_e mst;

    assign mst = master_e'(req_master);

    acc_region_decode #(.AW(AW)) u_decode (
        .addr (req_addr),
        .dec  (dec)
    );

    acc_policy u_policy (
        .master   (mst),
        .dec      (dec),
        .is_write (req_write),
        .level    (prot_level),
        .allow    (allow)
    );

    acc_level_reg #(.RST_LEVEL(RST_LEVEL)) u_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (lvl_wr_en),
        .wr_val (lvl_wr_val),
        .level  (prot_level)
    );

    acc_viol_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (viol),
        .count (viol_count)
    );

    // Response path: grant, masked data and violation flag.
    always_comb begin
        grant     = req_valid && allow;
        viol      = req_valid && !allow;
        rsp_rdata = grant ? mem_rdata : '0;
    end

    // R10
    blocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !grant) |-> (rsp_rdata == '0 && viol));

    // R8
    full_dbg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_master == 2'd3 && prot_level >= 2'd2) |-> !grant);

    // R3
    xo_only_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec.rgn == RGN_FLASH && dec.xo && req_master != 2'd0) |-> !grant);

    // R7
    part_dreg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_master == 2'd3 && prot_level != 2'd0 &&
         dec.rgn != RGN_RAM) |-> !grant);

endmodule

// File: tb/bm_access_gate_test.sv
`timescale 1ns/1ps
module bm_access_gate_test;

    localparam int CW = 4;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_master = 2'd0;
    logic [31:0]   req_addr = 32'd0;
    logic          req_write = 1'b0;
    logic [31:0]   mem_rdata;
    logic          lvl_wr_en = 1'b0;
    logic [1:0]    lvl_wr_val = 2'd0;
    logic          grant;
    logic [31:0]   rsp_rdata;
    logic          viol;
    logic [CW-1:0] viol_count;
    logic [1:0]    prot_level;

    int tests = 0;
    int fails = 0;
    logic [CW-1:0] m_cnt = '0;
    logic [1:0]    m_lvl = 2'd0;

    always #4 clk = ~clk;

    assign mem_rdata = req_addr ^ 32'h5A5A_0F0F;

    bm_access_gate #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_master(req_master),
        .req_addr(req_addr), .req_write(req_write), .mem_rdata(mem_rdata),
        .lvl_wr_en(lvl_wr_en), .lvl_wr_val(lvl_wr_val), .grant(grant),
        .rsp_rdata(rsp_rdata), .viol(viol), .viol_count(viol_count),
        .prot_level(prot_level)
    );

    typedef struct packed {
        logic [1:0]  lvl;
        logic [1:0]  mst;
        logic [31:0] addr;
        logic        wr;
        logic        exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 32'h0800_0100, 1'b0, 1'b1, 4'd4},  // R4
        '{2'd0, 2'd0, 32'h0800_8010, 1'b0, 1'b1, 4'd3},  // R3
        '{2'd0, 2'd0, 32'h0000_8010, 1'b0, 1'b1, 4'd2},  // R2
        '{2'd0, 2'd0, 32'h0800_0100, 1'b1, 1'b0, 4'd4},  // R4
        '{2'd0, 2'd1, 32'h0800_0100, 1'b0, 1'b1, 4'd5},  // R5
        '{2'd0, 2'd1, 32'h0000_0100, 1'b0, 1'b1, 4'd2},  // R2
        '{2'd0, 2'd1, 32'h0800_8010, 1'b0, 1'b0, 4'd3},  // R3
        '{2'd0, 2'd2, 32'h0000_8FFC, 1'b0, 1'b0, 4'd3},  // R3
        '{2'd0, 2'd2, 32'h0800_8000, 1'b1, 1'b0, 4'd3},  // R3
        '{2'd0, 2'd2, 32'h2000_0040, 1'b1, 1'b1, 4'd5},  // R5
        '{2'd0, 2'd1, 32'hE000_0004, 1'b0, 1'b0, 4'd5},  // R5
        '{2'd0, 2'd3, 32'hE000_0004, 1'b0, 1'b1, 4'd6},  // R6
        '{2'd0, 2'd3, 32'h0800_0100, 1'b0, 1'b1, 4'd6},  // R6
        '{2'd0, 2'd3, 32'h0800_8010, 1'b0, 1'b0, 4'd3},  // R3
        '{2'd0, 2'd3, 32'h4000_0000, 1'b0, 1'b0, 4'd1},  // R1
        '{2'd0, 2'd1, 32'h0801_0000, 1'b0, 1'b0, 4'd1},  // R1
        '{2'd0, 2'd1, 32'h2000_4000, 1'b0, 1'b0, 4'd1},  // R1
        '{2'd1, 2'd3, 32'h0800_0100, 1'b0, 1'b0, 4'd7},  // R7
        '{2'd1, 2'd3, 32'h0000_0100, 1'b0, 1'b0, 4'd7},  // R7 alias
        '{2'd1, 2'd3, 32'hE000_0004, 1'b1, 1'b0, 4'd7},  // R7
        '{2'd1, 2'd3, 32'h2000_0040, 1'b0, 1'b1, 4'd7},  // R7
        '{2'd1, 2'd0, 32'h0800_0100, 1'b0, 1'b1, 4'd4},  // R4
        '{2'd1, 2'd2, 32'h0800_0100, 1'b0, 1'b1, 4'd5},  // R5
        '{2'd2, 2'd3, 32'h2000_0040, 1'b0, 1'b0, 4'd8},  // R8
        '{2'd2, 2'd3, 32'hE000_0004, 1'b0, 1'b0, 4'd8},  // R8
        '{2'd2, 2'd0, 32'h0800_8010, 1'b0, 1'b1, 4'd4}   // R4
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request: combinational checks mid-cycle, counter after the edge (R9, R10, R11).
    task automatic do_req(input logic [1:0] mst, input logic [31:0] addr,
                          input logic wr, input logic exp, input string req);
        logic [31:0] exp_data;
        @(negedge clk);
        req_valid = 1'b1; req_master = mst; req_addr = addr; req_write = wr;
        #2;
        exp_data = exp ? (addr ^ 32'h5A5A_0F0F) : 32'd0;
        check(grant == exp, req, {31'd0, grant}, {31'd0, exp});
        check(viol == !exp && rsp_rdata == exp_data, req, rsp_rdata, exp_data);
        @(posedge clk);
        #1;
        if (!exp && m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
        req_valid = 1'b0;
        check(viol_count == m_cnt, "R11", {28'd0, viol_count}, {28'd0, m_cnt});
    endtask

    task automatic set_level(input logic [1:0] v);
        @(negedge clk);
        lvl_wr_en = 1'b1; lvl_wr_val = v;
        @(posedge clk);
        #1;
        lvl_wr_en = 1'b0;
        if (v > m_lvl) m_lvl = v;
        check(prot_level == m_lvl, "R12", {30'd0, prot_level}, {30'd0, m_lvl});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        lvl_wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = '0;
        m_lvl = 2'd0;
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R13-style reset state, tagged to R11 and R12
        check(prot_level == 2'd0, "R12", {30'd0, prot_level}, 32'd0);
        check(viol_count == '0, "R11", {28'd0, viol_count}, 32'd0);
        check(!grant && !viol, "R10", {30'd0, grant, viol}, 32'd0);

        foreach (VECS[i]) begin
            if (VECS[i].lvl != m_lvl) set_level(VECS[i].lvl);
            do_req(VECS[i].mst, VECS[i].addr, VECS[i].wr, VECS[i].exp,
                   $sformatf("R%0d vec%0d", VECS[i].rq, i));
        end

        // R12: lowering write ignored; debug RAM stays blocked (R8)
        set_level(2'd1);
        do_req(2'd3, 32'h2000_0040, 1'b0, 1'b0, "R12 lower ignored");
        set_level(2'd3);
        do_req(2'd3, 32'h2000_0040, 1'b0, 1'b0, "R8 level3");

        // R9: level write and request in one cycle judged at old level, next cycle at new
        do_reset();
        @(negedge clk);
        lvl_wr_en = 1'b1; lvl_wr_val = 2'd1;
        req_valid = 1'b1; req_master = 2'd3; req_addr = 32'h0800_0200; req_write = 1'b0;
        #2;
        check(grant == 1'b1, "R9 old level", {31'd0, grant}, 32'd1);
        @(posedge clk);
        #1;
        lvl_wr_en = 1'b0;
        req_valid = 1'b0;
        m_lvl = 2'd1;
        do_req(2'd3, 32'h0800_0200, 1'b0, 1'b0, "R9 first cycle");
        do_req(2'd3, 32'hE000_0010, 1'b0, 1'b0, "R7 dreg");

        // R11: saturation
        for (int k = 0; k < 20; k++)
            do_req(2'd1, 32'h9000_0000, 1'b0, 1'b0, "R1 sat");
        check(viol_count == CMAX, "R11 saturate", {28'd0, viol_count}, {28'd0, CMAX});
        do_req(2'd2, 32'h2000_0000, 1'b0, 1'b1, "R11 hold");

        do_reset();
        check(viol_count == '0 && prot_level == 2'd0, "R11 R12 reset",
              {26'd0, prot_level, viol_count}, 32'd0);
        do_req(2'd3, 32'hE000_0000, 1'b0, 1'b1, "R6 after reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule